// File: doc/BRIEF.md
# Eight-Bit Timer/Counter with Shared Prescaler and Watchdog

This block is an 8-bit up-counter that software can load over a small write port. It counts either instruction-cycle strobes from the core or edges on an external input pin. The external pin is first passed through a two-flop synchroniser, and a control bit chooses which edge direction counts. An 8-bit prescaler can sit in front of the counter, and a 1-of-8 tap selects the divide ratio. The same prescaler can instead be handed to a small watchdog, so the timer and the watchdog never use it at the same time.

When the count wraps to zero, a sticky overflow flag is set, and only a software write clears it. The interrupt output is that flag gated by an enable bit. A write to the count register holds off the next two increment events, and a sleep input stops the timer entirely. The watchdog counts instruction strobes and is restarted by a kick input. It emits a one-cycle timeout pulse at the end of each period, and that period is stretched by the prescaler when the prescaler belongs to the watchdog.

Top module: `tmr8_unit`

## Requirements
- R1: After reset the count is 00h, the flag, the enable, `irq_o` and `wdt_to_o` are 0, and the control register reads 3Fh.
- R2: With ctrl[5]=0 and ctrl[3]=1, each cycle with `cyc_tick`=1 raises the count by one at the following clock edge.
- R3: With ctrl[5]=1, a pin edge counts: rising edges when ctrl[4]=0 and falling edges when ctrl[4]=1. A pin change sampled at clock edge k shows in the count after edge k+2.
- R4: With ctrl[3]=0, the count advances once every 2^(n+1) source events, where n=ctrl[2:0].
- R5: A write with `wr_addr`=0 loads the count from `wr_data`. The next two increment events are then discarded, and when ctrl[3]=0 the prescaler is cleared.
- R6: A wrap from FFh to 00h sets the flag. The flag stays set until a write with `wr_addr`=2 and `wr_data[0]`=0 clears it, and a wrap in the same cycle as that write wins.
- R7: A write with `wr_addr`=2 sets the enable from `wr_data[1]` and the flag from `wr_data[0]`. `irq_o` equals flag AND enable, so clearing the enable leaves the flag unchanged.
- R8: While `sleep` is 1 the count does not increment in either source mode.
- R9: `wdt_to_o` pulses for one cycle every 2^WDT_BASE_W strobes when ctrl[3]=0, and every 2^WDT_BASE_W·2^(n+1) strobes when ctrl[3]=1. `wdt_kick` restarts the period.
- R10: A control write (`wr_addr`=1, data[5:0]) that changes ctrl[3] clears the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_tick | input | 1 | Instruction-cycle strobe |
| ext_pin | input | 1 | Asynchronous external count input |
| sleep | input | 1 | Stops the timer while high |
| wdt_kick | input | 1 | Restarts the watchdog period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 count, 1 control, 2 interrupt, 3 unused |
| wr_data | input | 8 | Write data |
| count_o | output | 8 | Current count |
| ctrl_o | output | 6 | Control register |
| flag_o | output | 1 | Overflow flag |
| ien_o | output | 1 | Interrupt enable |
| irq_o | output | 1 | Interrupt request |
| wdt_to_o | output | 1 | Watchdog timeout pulse |

## Verification
The hardest case to reach is the overlap of prescaler state with the write inhibit and with reassignment of the prescaler. Examples are a count write landing mid-division, inhibited events that themselves come out of the divider, and a control write that moves the prescaler to the watchdog and back. The directed steps build these overlaps on purpose, for example by leaving the divider part-filled before a reassignment. The random stretch then mixes writes, kicks, sleep and pin toggles against a cycle-level model, so that collisions happen in many phases of the divider.

// File: rtl/tmr8_pkg.sv
`timescale 1ns/1ps
package tmr8_pkg;
    parameter int CNT_W  = 8;
    parameter int CTL_W  = 6;
    parameter int INH_W  = 2;
    localparam int SRC_BIT  = 5;
    localparam int EDGE_BIT = 4;
    localparam int PSA_BIT  = 3;
    localparam logic [CTL_W-1:0] CTL_RESET = 6'h3F;
    localparam logic [INH_W-1:0] INH_LOAD  = 2'd2;

    typedef enum logic [1:0] {
        REG_CNT  = 2'd0,
        REG_CTL  = 2'd1,
        REG_IRQ  = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CTL_W-1:0] ctl;
        logic             flag;
        logic             ien;
        logic [INH_W-1:0] inh;
        logic             wto;
    } tmr_state_t;
endpackage

// File: rtl/tmr8_edge.sv
`timescale 1ns/1ps
module tmr8_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic fall_sel,
    output logic evt
);
    localparam int LAST = SYNC_STAGES;

    logic [LAST:0] chain_d, chain_q;
    logic          rise, fall;

    always_comb begin
        chain_d = {chain_q[LAST-1:0], pin};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign rise = chain_q[LAST-1] & ~chain_q[LAST];
    assign fall = ~chain_q[LAST-1] & chain_q[LAST];
    assign evt  = fall_sel ? fall : rise;
endmodule

// File: rtl/tmr8_presc.sv
`timescale 1ns/1ps
module tmr8_presc #(
    parameter int PRE_W = 8,
    parameter int TAP_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    input  logic [TAP_W-1:0] tap,
    output logic             full
);
    localparam int NTAPS = 1 << TAP_W;

    logic [PRE_W-1:0] cnt_d, cnt_q;
    logic [NTAPS-1:0] tap_full;

    generate
        for (genvar i = 0; i < NTAPS; i++) begin : g_tap
            assign tap_full[i] = &cnt_q[i:0];
        end
    endgenerate

    assign full = tap_full[tap];

    always_comb begin
        cnt_d = cnt_q;
        if (clr)      cnt_d = '0;
        else if (adv) cnt_d = cnt_q + {{(PRE_W-1){1'b0}}, 1'b1};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/tmr8_wbase.sv
`timescale 1ns/1ps
module tmr8_wbase #(
    parameter int BASE_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    input  logic adv,
    output logic wrap
);
    logic [BASE_W-1:0] base_d, base_q;

    assign wrap = adv && (&base_q);

    always_comb begin
        base_d = base_q;
        if (kick)     base_d = '0;
        else if (adv) base_d = base_q + {{(BASE_W-1){1'b0}}, 1'b1};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) base_q <= '0;
        else        base_q <= base_d;
    end
endmodule

// File: rtl/tmr8_unit.sv
`timescale 1ns/1ps
module tmr8_unit
    import tmr8_pkg::*;
#(
    parameter int PRE_W       = 8,
    parameter int TAP_W       = 3,
    parameter int WDT_BASE_W  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_tick,
    input  logic             ext_pin,
    input  logic             sleep,
    input  logic             wdt_kick,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count_o,
    output logic [CTL_W-1:0] ctrl_o,
    output logic             flag_o,
    output logic             ien_o,
    output logic             irq_o,
    output logic             wdt_to_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    tmr_state_t st_d, st_q;

    logic ext_evt, src_tick, psa;
    logic pre_clr, pre_adv, pre_full;
    logic base_wrap, inc_evt, wdt_fire;
    logic wr_cnt, wr_ctl, wr_irq, wrap_now;

    tmr8_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (ext_pin),
        .fall_sel (st_q.ctl[EDGE_BIT]),
        .evt      (ext_evt)
    );

    tmr8_presc #(.PRE_W(PRE_W), .TAP_W(TAP_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (pre_clr),
        .adv   (pre_adv),
        .tap   (st_q.ctl[TAP_W-1:0]),
        .full  (pre_full)
    );

    tmr8_wbase #(.BASE_W(WDT_BASE_W)) u_wbase (
        .clk   (clk),
        .rst_n (rst_n),
        .kick  (wdt_kick),
        .adv   (cyc_tick),
        .wrap  (base_wrap)
    );

    always_comb begin
        st_d     = st_q;
        wr_cnt   = wr_en && (wr_addr == REG_CNT);
        wr_ctl   = wr_en && (wr_addr == REG_CTL);
        wr_irq   = wr_en && (wr_addr == REG_IRQ);
        psa      = st_q.ctl[PSA_BIT];
        src_tick = (st_q.ctl[SRC_BIT] ? ext_evt : cyc_tick) && !sleep;

        // prescaler ownership: 1 = watchdog, 0 = timer
        pre_clr  = (wr_cnt && !psa) || (wdt_kick && psa)
                 || (wr_ctl && (wr_data[PSA_BIT] != psa));
        pre_adv  = psa ? base_wrap : src_tick;
        inc_evt  = psa ? src_tick : (src_tick && pre_full);
        wdt_fire = !wdt_kick && base_wrap && (!psa || pre_full);
        wrap_now = 1'b0;

        if (wr_cnt) begin
            st_d.cnt = wr_data;
            st_d.inh = INH_LOAD;
        end else if (inc_evt) begin
            if (st_q.inh != '0) begin
                st_d.inh = st_q.inh - 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
                wrap_now = (st_q.cnt == CNT_MAX);
            end
        end

        if (wr_ctl) st_d.ctl = wr_data[CTL_W-1:0];

        if (wr_irq) begin
            st_d.ien  = wr_data[1];
            st_d.flag = wr_data[0];
        end
        if (wrap_now) st_d.flag = 1'b1;

        st_d.wto = wdt_fire;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt  <= '0;
            st_q.ctl  <= CTL_RESET;
            st_q.flag <= 1'b0;
            st_q.ien  <= 1'b0;
            st_q.inh  <= '0;
            st_q.wto  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o  = st_q.cnt;
    assign ctrl_o   = st_q.ctl;
    assign flag_o   = st_q.flag;
    assign ien_o    = st_q.ien;
    assign irq_o    = st_q.flag & st_q.ien;
    assign wdt_to_o = st_q.wto;
endmodule

// File: rtl/tmr8_unit_chk.sv
`timescale 1ns/1ps
module tmr8_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sleep,
    input logic       wr_en,
    input logic [1:0] wr_addr,
    input logic [7:0] wr_data,
    input logic [7:0] count_o,
    input logic       flag_o,
    input logic       ien_o,
    input logic       irq_o,
    input logic       wdt_to_o
);
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == 2'd0) |=> (count_o == $past(count_o) || count_o == $past(count_o) + 8'd1)); // R2
    AST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd0) |=> count_o == $past(wr_data)); // R5
    AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == 8'h00 && $past(count_o) == 8'hFF && !$past(wr_en && wr_addr == 2'd0)) |-> flag_o); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !(wr_en && wr_addr == 2'd2)) |=> flag_o); // R6
    AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (flag_o && ien_o)); // R7
    AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep && !(wr_en && wr_addr == 2'd0)) |=> $stable(count_o)); // R8
    AST_WDT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_to_o |=> !wdt_to_o); // R9
endmodule

bind tmr8_unit tmr8_unit_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sleep    (sleep),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .count_o  (count_o),
    .flag_o   (flag_o),
    .ien_o    (ien_o),
    .irq_o    (irq_o),
    .wdt_to_o (wdt_to_o)
);

// File: tb/tmr8_unit_test.sv
`timescale 1ns/1ps
module tmr8_unit_test;
    localparam int WB = 4;

    logic clk = 1'b0;
    logic rst_n, cyc_tick, ext_pin, sleep, wdt_kick, wr_en;
    logic [1:0] wr_addr;
    logic [7:0] wr_data, count_o;
    logic [5:0] ctrl_o;
    logic flag_o, ien_o, irq_o, wdt_to_o;

    int checks = 0;
    int errors = 0;
    logic pin_lvl = 1'b0;

    // bench model state
    logic [7:0] m_cnt, m_pre;
    logic [5:0] m_ctl;
    logic m_flag, m_ien, m_wto, m_s1, m_s2, m_s3;
    logic [1:0] m_inh;
    logic [WB-1:0] m_wb;

    always #10 clk = ~clk;

    tmr8_unit uut (
        .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .ext_pin(ext_pin),
        .sleep(sleep), .wdt_kick(wdt_kick), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .count_o(count_o), .ctrl_o(ctrl_o), .flag_o(flag_o),
        .ien_o(ien_o), .irq_o(irq_o), .wdt_to_o(wdt_to_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cnt = 0; m_pre = 0; m_ctl = 6'h3F; m_flag = 0; m_ien = 0;
        m_wto = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0; m_inh = 0; m_wb = 0;
    endtask

    task automatic model_step(input logic cyc, pin, slp, kick, we,
                              input logic [1:0] a, input logic [7:0] d);
        logic ext, tick, psa, pclr, padv, pfull, inc, btick, ovf;
        logic [8:0] mask;
        ext   = m_ctl[4] ? (!m_s2 && m_s3) : (m_s2 && !m_s3);
        tick  = (m_ctl[5] ? ext : cyc) && !slp;
        psa   = m_ctl[3];
        mask  = (9'd1 << (m_ctl[2:0] + 1)) - 9'd1;
        pfull = ({1'b0, m_pre} & mask) == mask;
        btick = cyc && (m_wb == {WB{1'b1}});
        pclr  = (we && a == 0 && !psa) || (kick && psa) || (we && a == 1 && d[3] != psa);
        padv  = psa ? btick : tick;
        inc   = psa ? tick : (tick && pfull);
        ovf   = 0;
        m_wto = !kick && btick && (!psa || pfull);
        m_pre = pclr ? 8'd0 : (padv ? m_pre + 8'd1 : m_pre);
        m_wb  = kick ? '0 : (cyc ? m_wb + 1'b1 : m_wb);
        if (we && a == 0) begin
            m_cnt = d; m_inh = 2;
        end else if (inc) begin
            if (m_inh != 0) m_inh = m_inh - 1;
            else begin ovf = (m_cnt == 8'hFF); m_cnt = m_cnt + 8'd1; end
        end
        if (we && a == 1) m_ctl = d[5:0];
        if (we && a == 2) begin m_ien = d[1]; m_flag = d[0]; end
        if (ovf) m_flag = 1;
        m_s3 = m_s2; m_s2 = m_s1; m_s1 = pin;
    endtask

    task automatic step(input logic cyc, pin, slp, kick, we,
                        input logic [1:0] a, input logic [7:0] d);
        cyc_tick = cyc; ext_pin = pin; sleep = slp; wdt_kick = kick;
        wr_en = we; wr_addr = a; wr_data = d;
        model_step(cyc, pin, slp, kick, we, a, d);
        @(negedge clk);
        chk("R4 count vs model", count_o, m_cnt);
        chk("R6 flag vs model", flag_o, m_flag);
        chk("R7 irq vs model", irq_o, m_flag & m_ien);
        chk("R9 wdt vs model", wdt_to_o, m_wto);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, pin_lvl, 0, 0, 0, 0, 0);
    endtask
    task automatic strobe(input int n, input logic slp);
        for (int i = 0; i < n; i++) step(1, pin_lvl, slp, 0, 0, 0, 0);
    endtask
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        step(0, pin_lvl, 0, 0, 1, a, d);
    endtask
    task automatic pulses(input int n, input logic slp);
        for (int i = 0; i < n; i++) begin
            pin_lvl = 1; for (int j = 0; j < 3; j++) step(0, 1, slp, 0, 0, 0, 0);
            pin_lvl = 0; for (int j = 0; j < 3; j++) step(0, 0, slp, 0, 0, 0, 0);
        end
    endtask
    function automatic int div_of(input int n);
        return 1 << (n + 1);
    endfunction

    task automatic wdt_period(input int exp, input string tag);
        int n;
        step(1, pin_lvl, 0, 1, 0, 0, 0);
        n = 0;
        do begin step(1, pin_lvl, 0, 0, 0, 0, 0); n++; end
        while (!wdt_to_o && n < 2000);
        chk(tag, n, exp);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; cyc_tick = 0; ext_pin = 0; sleep = 0; wdt_kick = 0;
        wr_en = 0; wr_addr = 0; wr_data = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk("R1 count", count_o, 0);
        chk("R1 ctrl", ctrl_o, 6'h3F);
        chk("R1 flag", flag_o, 0);
        chk("R1 ien", ien_o, 0);
        chk("R1 irq", irq_o, 0);
        chk("R1 wdt", wdt_to_o, 0);

        // R2 + R5: timer mode, prescaler on watchdog
        wr(1, 8'b001000);
        wr(0, 8'h10);
        strobe(2, 0);
        chk("R5 inhibit holds load", count_o, 8'h10);
        strobe(5, 0);
        chk("R2 timer count", count_o, 8'h15);

        // R4: prescaler on timer, tap 2
        wr(1, 8'b000010);
        wr(0, 8'h00);
        strobe(2 * div_of(2), 0);
        chk("R5 inhibit through prescaler", count_o, 0);
        strobe(3 * div_of(2), 0);
        chk("R4 divide by 8", count_o, 3);
        wr(1, 8'b000110);
        wr(0, 8'h00);
        strobe(2 * div_of(6) + div_of(6) - 1, 0);
        chk("R4 divide by 128 before", count_o, 0);
        strobe(1, 0);
        chk("R4 divide by 128 edge", count_o, 1);

        // R10: reassignment clears prescaler
        wr(1, 8'b000010);
        wr(0, 8'h00);
        strobe(2 * div_of(2), 0);
        strobe(5, 0);
        wr(1, 8'b001010);
        wr(1, 8'b000010);
        strobe(7, 0);
        chk("R10 cleared prescaler", count_o, 0);
        strobe(1, 0);
        chk("R10 full period", count_o, 1);

        // R3: external edges
        wr(1, 8'b101000);
        wr(0, 8'hF0);
        pulses(8, 0);
        chk("R3 rising edges", count_o, 8'hF6);
        wr(1, 8'b111000);
        pulses(3, 0);
        chk("R3 falling edges", count_o, 8'hF9);
        pin_lvl = 1; step(0, 1, 0, 0, 0, 0, 0); step(0, 1, 0, 0, 0, 0, 0);
        chk("R3 sync latency", count_o, 8'hF9);
        pin_lvl = 0; step(0, 0, 0, 0, 0, 0, 0); step(0, 0, 0, 0, 0, 0, 0);
        chk("R3 falling two edges later", count_o, 8'hF9);
        step(0, 0, 0, 0, 0, 0, 0);
        chk("R3 falling counted", count_o, 8'hFA);

        // R6 + R7: overflow and mask
        wr(1, 8'b001000);
        wr(0, 8'hFE);
        strobe(3, 0);
        chk("R6 no flag at FF", flag_o, 0);
        strobe(1, 0);
        chk("R6 wrap count", count_o, 0);
        chk("R6 flag set", flag_o, 1);
        chk("R7 masked irq", irq_o, 0);
        wr(2, 8'b11);
        chk("R7 irq enabled", irq_o, 1);
        wr(2, 8'b01);
        chk("R7 mask keeps flag", flag_o, 1);
        chk("R7 irq masked", irq_o, 0);
        wr(2, 8'b00);
        chk("R6 software clear", flag_o, 0);

        // R8: sleep
        wr(0, 8'h40);
        strobe(2, 0);
        strobe(10, 1);
        chk("R8 timer frozen", count_o, 8'h40);
        wr(1, 8'b101000);
        pulses(2, 1);
        chk("R8 counter frozen", count_o, 8'h40);
        wr(1, 8'b001000);
        strobe(3, 0);
        chk("R8 resumes", count_o, 8'h43);

        // R9: watchdog periods
        wr(1, 8'b000000);
        wdt_period(1 << WB, "R9 base period");
        wr(1, 8'b001001);
        wdt_period((1 << WB) * div_of(1), "R9 prescaled period");

        // mixed random traffic against the model
        void'($urandom(32'h5A17));
        for (int i = 0; i < 4000; i++) begin
            logic we;
            if ($urandom_range(0, 7) == 0) pin_lvl = ~pin_lvl;
            we = ($urandom_range(0, 15) == 0);
            step($urandom_range(0, 1), pin_lvl, $urandom_range(0, 19) == 0,
                 $urandom_range(0, 63) == 0, we, 2'($urandom_range(0, 3)),
                 8'($urandom_range(0, 255)));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule